// File: doc/BRIEF.md
# Shadowed Video Timing Generator

This block generates the horizontal sync, vertical sync and data-enable signals for a display path. It also reports the current pixel position within the line and the current line position within the frame. It runs on the pixel clock and advances one pixel per cycle. A line is built from four phases in a fixed order: sync, back porch, active, front porch. A frame is built from the same four phases counted in lines.

Software programs the timing through a small write port. Each of the four timing words packs two 16-bit parameters, and every write lands in a shadow copy. Writing the upload word with bit 0 set arms an upload request. The armed request copies the shadow bank into the working bank on the last pixel of the current frame, so no frame ever runs on a mix of old and new values. A video path control word is also held: a 10-bit vertical sync delay, a pixel-format select and a 6-bit-mode flag. These fields are driven straight to configuration outputs.

The upload request is tracked by a two-state machine. In state UP_IDLE nothing is pending; an upload write moves it to UP_ARMED. In UP_ARMED the frame wrap moves it back to UP_IDLE, unless a new upload write arrives in that same cycle, in which case it stays in UP_ARMED. Each line and frame sequencer walks the states PH_SYNC, PH_BACK, PH_ACTIVE and PH_FRONT, and then returns to PH_SYNC. Each phase lasts the number of cycles (or lines) that its field holds.

Top module: `vtg_core`

## Requirements
- R1: While reset is held and in the first cycle after it, h_pos and v_pos are 0, hsync and vsync are 1 and de is 0. The reset working bank is: sync 2, back 3, active 8 and front 2 pixels; sync 1, back 1, active 3 and front 1 lines.
- R2: Each line starts at h_pos 0, with hsync high for the sync width. It then passes through back porch, active and front porch. h_pos increments by one every cycle and wraps to 0 after the line total, which is the sum of the four horizontal widths.
- R3: v_pos increments once per line, on the cycle after the last pixel of a line, and wraps to 0 after the frame total of lines. vsync is high for the lines of the vertical sync phase.
- R4: de is 1 exactly when the horizontal position is in its active phase and the vertical position is in its active phase.
- R5: A width field of 0 in any of the eight timing fields is handled as a width of 1.
- R6: The timing words sit at these addresses. Address 0 holds the horizontal back porch in bits 31:16 and the horizontal sync in bits 15:0. Address 1 holds the horizontal front porch in bits 31:16 and active pixels in bits 15:0. Address 2 holds the vertical back porch and sync in the same layout. Address 3 holds the vertical front porch and active lines in the same layout. A write changes only the shadow copy, which reads back at the same address. The working timing stays as it was until an upload commits.
- R7: A write to address 4 with bit 0 set arms an upload, and address 4 then reads 1. A write to address 4 with bit 0 clear has no effect. On the last pixel of the frame, the armed upload copies all four shadow words into the working bank, and address 4 reads 0 from then on.
- R8: An upload write in the same cycle as the frame's last pixel is not consumed by that boundary: it stays armed and commits at the next one. A shadow write in the cycle of a commit is left out of that commit.
- R9: A write to address 5 stores the path control fields: vertical sync delay from bits 29:20, format select from bit 8 and 6-bit flag from bit 0. They appear on cfg_vs_delay, cfg_fmt_sel and cfg_six_bit in the next cycle. Address 5 reads back only these bits, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| h_pos | output | 18 | Pixel position within the line |
| v_pos | output | 18 | Line position within the frame |
| cfg_vs_delay | output | 10 | Vertical sync delay setting |
| cfg_fmt_sel | output | 1 | Pixel-format select |
| cfg_six_bit | output | 1 | 6-bit mode flag |

## Verification
The critical coincidence is a register write that lands in the same cycle as the frame's last pixel. Two such writes matter: an upload strobe, and a shadow write while an upload is armed. The bench tracks the frame position in its own model and issues these writes exactly on that pixel. It then reads the upload word back, expecting it still armed after the strobe case. It also compares every following cycle of sync, data-enable and positions against timing expected from the pre-write shadow contents.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    typedef enum logic {
        UP_IDLE  = 1'b0,
        UP_ARMED = 1'b1
    } upload_e;

    localparam int ADR_HT1    = 0;
    localparam int ADR_HT2    = 1;
    localparam int ADR_VT1    = 2;
    localparam int ADR_VT2    = 3;
    localparam int ADR_UPLOAD = 4;
    localparam int ADR_PATH   = 5;

    localparam int NUM_TWORDS = 4;
    localparam int VSD_LSB    = 20;
    localparam int FMT_BIT    = 8;
    localparam int SIX_BIT    = 0;

endpackage

// File: rtl/vtg_phase_seq.sv
module vtg_phase_seq
    import vtg_pkg::*;
#(
    parameter int FW    = 16,
    parameter int POS_W = FW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic [3:0][FW-1:0]   len_in,
    output logic [POS_W-1:0]     pos,
    output logic                 in_sync,
    output logic                 in_active,
    output logic                 wrap
);

    logic [3:0][FW-1:0] eff;
    phase_e             ph_q, ph_d;
    logic [FW-1:0]      cnt_q, cnt_d;
    logic [POS_W-1:0]   pos_q;
    logic               last;

    // a zero width is clamped to one so every phase lasts at least one step
    for (genvar i = 0; i < 4; i++) begin : g_clamp
        assign eff[i] = (len_in[i] == '0) ? FW'(1) : len_in[i];
    end

    assign last = (cnt_q == eff[ph_q] - FW'(1));
    assign wrap = step && last && (ph_q == PH_FRONT);
    assign pos  = pos_q;

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q + FW'(1);
        if (last) begin
            cnt_d = '0;
            unique case (ph_q)
                PH_SYNC:   ph_d = PH_BACK;
                PH_BACK:   ph_d = PH_ACTIVE;
                PH_ACTIVE: ph_d = PH_FRONT;
                PH_FRONT:  ph_d = PH_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_SYNC;
            cnt_q <= '0;
            pos_q <= '0;
        end else if (step) begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            pos_q <= wrap ? '0 : pos_q + POS_W'(1);
        end
    end

    always_comb begin
        in_sync   = 1'b0;
        in_active = 1'b0;
        unique case (ph_q)
            PH_SYNC:   in_sync   = 1'b1;
            PH_ACTIVE: in_active = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int              FW      = 16,
    parameter int              ADDR_W  = 3,
    parameter int              VSD_W   = 10,
    parameter logic [2*FW-1:0] RST_HT1 = 32'h0003_0002,
    parameter logic [2*FW-1:0] RST_HT2 = 32'h0002_0008,
    parameter logic [2*FW-1:0] RST_VT1 = 32'h0001_0001,
    parameter logic [2*FW-1:0] RST_VT2 = 32'h0001_0003
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [2*FW-1:0]                   wr_data,
    input  logic                              up_req,
    input  logic                              frame_wrap,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [2*FW-1:0]                   rd_data,
    output logic [NUM_TWORDS-1:0][2*FW-1:0]   act_bank,
    output logic                              pending,
    output logic [VSD_W-1:0]                  ctl_vs_delay,
    output logic                              ctl_fmt,
    output logic                              ctl_six
);

    localparam int DW = 2 * FW;
    localparam logic [NUM_TWORDS-1:0][DW-1:0] RST_BANK =
        {RST_VT2, RST_VT1, RST_HT2, RST_HT1};

    logic [NUM_TWORDS-1:0][DW-1:0] shadow_q;
    logic [NUM_TWORDS-1:0][DW-1:0] active_q;
    upload_e                       up_q, up_d;
    logic                          commit;

    assign commit   = (up_q == UP_ARMED) && frame_wrap;
    assign pending  = (up_q == UP_ARMED);
    assign act_bank = active_q;

    // upload request state machine
    always_comb begin
        up_d = up_q;
        unique case (up_q)
            UP_IDLE:  if (up_req) up_d = UP_ARMED;
            UP_ARMED: if (frame_wrap && !up_req) up_d = UP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= UP_IDLE;
        else        up_q <= up_d;
    end

    for (genvar i = 0; i < NUM_TWORDS; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[i] <= RST_BANK[i];
                active_q[i] <= RST_BANK[i];
            end else begin
                if (wr_en && wr_addr == ADDR_W'(i)) shadow_q[i] <= wr_data;
                if (commit) active_q[i] <= shadow_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_vs_delay <= '0;
            ctl_fmt      <= 1'b0;
            ctl_six      <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_W'(ADR_PATH)) begin
            ctl_vs_delay <= wr_data[VSD_LSB +: VSD_W];
            ctl_fmt      <= wr_data[FMT_BIT];
            ctl_six      <= wr_data[SIX_BIT];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_HT1))    rd_data = shadow_q[ADR_HT1];
        if (rd_addr == ADDR_W'(ADR_HT2))    rd_data = shadow_q[ADR_HT2];
        if (rd_addr == ADDR_W'(ADR_VT1))    rd_data = shadow_q[ADR_VT1];
        if (rd_addr == ADDR_W'(ADR_VT2))    rd_data = shadow_q[ADR_VT2];
        if (rd_addr == ADDR_W'(ADR_UPLOAD)) rd_data[0] = pending;
        if (rd_addr == ADDR_W'(ADR_PATH)) begin
            rd_data[VSD_LSB +: VSD_W] = ctl_vs_delay;
            rd_data[FMT_BIT]          = ctl_fmt;
            rd_data[SIX_BIT]          = ctl_six;
        end
    end

endmodule

// File: rtl/vtg_core.sv
module vtg_core
    import vtg_pkg::*;
#(
    parameter int              FW      = 16,
    parameter int              ADDR_W  = 3,
    parameter int              VSD_W   = 10,
    parameter logic [2*FW-1:0] RST_HT1 = 32'h0003_0002,
    parameter logic [2*FW-1:0] RST_HT2 = 32'h0002_0008,
    parameter logic [2*FW-1:0] RST_VT1 = 32'h0001_0001,
    parameter logic [2*FW-1:0] RST_VT2 = 32'h0001_0003
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [2*FW-1:0]     wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [2*FW-1:0]     rd_data,
    output logic                hsync,
    output logic                vsync,
    output logic                de,
    output logic [FW+1:0]       h_pos,
    output logic [FW+1:0]       v_pos,
    output logic [VSD_W-1:0]    cfg_vs_delay,
    output logic                cfg_fmt_sel,
    output logic                cfg_six_bit
);

    localparam int POS_W = FW + 2;

    logic [NUM_TWORDS-1:0][2*FW-1:0] act_bank;
    logic [3:0][FW-1:0]              h_len, v_len;
    logic                            up_req, upload_pending;
    logic                            h_wrap, v_wrap, frame_wrap;
    logic                            h_act, v_act;

    assign up_req = wr_en && (wr_addr == ADDR_W'(ADR_UPLOAD)) && wr_data[0];

    // phase order in each length vector: sync, back, active, front
    assign h_len = {act_bank[ADR_HT2][2*FW-1:FW], act_bank[ADR_HT2][FW-1:0],
                    act_bank[ADR_HT1][2*FW-1:FW], act_bank[ADR_HT1][FW-1:0]};
    assign v_len = {act_bank[ADR_VT2][2*FW-1:FW], act_bank[ADR_VT2][FW-1:0],
                    act_bank[ADR_VT1][2*FW-1:FW], act_bank[ADR_VT1][FW-1:0]};

    assign frame_wrap = v_wrap;

    vtg_regs #(
        .FW(FW), .ADDR_W(ADDR_W), .VSD_W(VSD_W),
        .RST_HT1(RST_HT1), .RST_HT2(RST_HT2),
        .RST_VT1(RST_VT1), .RST_VT2(RST_VT2)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .up_req       (up_req),
        .frame_wrap   (frame_wrap),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .act_bank     (act_bank),
        .pending      (upload_pending),
        .ctl_vs_delay (cfg_vs_delay),
        .ctl_fmt      (cfg_fmt_sel),
        .ctl_six      (cfg_six_bit)
    );

    vtg_phase_seq #(.FW(FW), .POS_W(POS_W)) u_hseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (1'b1),
        .len_in    (h_len),
        .pos       (h_pos),
        .in_sync   (hsync),
        .in_active (h_act),
        .wrap      (h_wrap)
    );

    vtg_phase_seq #(.FW(FW), .POS_W(POS_W)) u_vseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (h_wrap),
        .len_in    (v_len),
        .pos       (v_pos),
        .in_sync   (vsync),
        .in_active (v_act),
        .wrap      (v_wrap)
    );

    assign de = h_act && v_act;

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int FW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hsync,
    input logic                  vsync,
    input logic                  de,
    input logic [FW+1:0]         h_pos,
    input logic [FW+1:0]         v_pos,
    input logic                  pending,
    input logic                  frame_wrap,
    input logic                  upload_req,
    input logic [3:0][2*FW-1:0]  act_bank
);

    assert_line_start_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos == '0) |-> hsync);

    assert_hpos_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos != '0) |-> (h_pos == $past(h_pos) + 1'b1));

    assert_vpos_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos != '0) |-> $stable(v_pos));

    assert_de_outside_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));

    assert_bank_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_bank) |-> $past(frame_wrap));

    assert_upload_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && frame_wrap && !upload_req) |=> !pending);

    assert_request_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upload_req |=> pending);

endmodule

bind vtg_core vtg_checker #(.FW(FW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync      (hsync),
    .vsync      (vsync),
    .de         (de),
    .h_pos      (h_pos),
    .v_pos      (v_pos),
    .pending    (upload_pending),
    .frame_wrap (frame_wrap),
    .upload_req (up_req),
    .act_bank   (act_bank)
);

// File: tb/vtg_core_tb.sv
`timescale 1ns/1ps
module vtg_core_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic        hsync, vsync, de;
    logic [17:0] h_pos, v_pos;
    logic [9:0]  cfg_vs_delay;
    logic        cfg_fmt_sel, cfg_six_bit;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_sh [4];
    logic [31:0] m_act[4];
    logic [31:0] m_ctl;
    bit          m_pend;
    int          x, y;

    always #10 clk = ~clk;

    vtg_core u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hsync(hsync), .vsync(vsync), .de(de), .h_pos(h_pos), .v_pos(v_pos),
        .cfg_vs_delay(cfg_vs_delay), .cfg_fmt_sel(cfg_fmt_sel),
        .cfg_six_bit(cfg_six_bit)
    );

    function automatic int eff(input logic [15:0] v);
        return (v == 16'd0) ? 1 : int'(v);
    endfunction

    function automatic int htot();
        return eff(m_act[0][15:0]) + eff(m_act[0][31:16]) +
               eff(m_act[1][15:0]) + eff(m_act[1][31:16]);
    endfunction

    function automatic int vtot();
        return eff(m_act[2][15:0]) + eff(m_act[2][31:16]) +
               eff(m_act[3][15:0]) + eff(m_act[3][31:16]);
    endfunction

    // 0 sync, 1 back, 2 active, 3 front
    function automatic int phase_of(input int p, input int s, input int b, input int a);
        if (p < s)         return 0;
        if (p < s + b)     return 1;
        if (p < s + b + a) return 2;
        return 3;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp,
                         input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        int hp, vp;
        hp = phase_of(x, eff(m_act[0][15:0]), eff(m_act[0][31:16]), eff(m_act[1][15:0]));
        vp = phase_of(y, eff(m_act[2][15:0]), eff(m_act[2][31:16]), eff(m_act[3][15:0]));
        check("R2", 64'(hsync), 64'(hp == 0), "hsync");
        check("R2", 64'(h_pos), 64'(x), "h_pos");
        check("R3", 64'(vsync), 64'(vp == 0), "vsync");
        check("R3", 64'(v_pos), 64'(y), "v_pos");
        check("R4", 64'(de), 64'(hp == 2 && vp == 2), "de");
        check("R9", 64'({cfg_vs_delay, cfg_fmt_sel, cfg_six_bit}),
              64'({m_ctl[29:20], m_ctl[8], m_ctl[0]}), "cfg outputs");
    endtask

    task automatic tick(input bit w, input logic [2:0] a, input logic [31:0] d);
        bit last;
        int ht, vt;
        wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        ht = htot(); vt = vtot();
        last = (x == ht - 1) && (y == vt - 1);
        if (m_pend && last) for (int i = 0; i < 4; i++) m_act[i] = m_sh[i];
        if (w && a < 3'd4) m_sh[a[1:0]] = d;
        if (w && a == 3'd5) m_ctl = d & 32'h3FF0_0101;
        m_pend = (m_pend && !last) || (w && a == 3'd4 && d[0]);
        if (x == ht - 1) begin
            x = 0;
            y = (y == vt - 1) ? 0 : y + 1;
        end else begin
            x = x + 1;
        end
        @(negedge clk);
        wr_en = 1'b0;
        compare_outputs();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(0, 3'd0, 32'd0);
    endtask

    task automatic run_to_last();
        for (int i = 0; i < 5000; i++) begin
            if (x == htot() - 1 && y == vtot() - 1) break;
            tick(0, 3'd0, 32'd0);
        end
    endtask

    task automatic wait_commit();
        for (int i = 0; i < 20000; i++) begin
            if (!m_pend) break;
            tick(0, 3'd0, 32'd0);
        end
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(tag, 64'(rd_data), 64'(exp), "readback");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_set;
        logic [31:0] w0, w1, w2, w3;
        seed_set = $urandom(32'd4711);
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        m_sh[0] = 32'h0003_0002; m_sh[1] = 32'h0002_0008;
        m_sh[2] = 32'h0001_0001; m_sh[3] = 32'h0001_0003;
        for (int i = 0; i < 4; i++) m_act[i] = m_sh[i];
        m_ctl = '0; m_pend = 0; x = 0; y = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", 64'(h_pos), 64'd0, "h_pos in reset");
        check("R1", 64'(v_pos), 64'd0, "v_pos in reset");
        check("R1", 64'({hsync, vsync, de}), 64'b110, "sync/de in reset");
        rst_n = 1'b1;
        compare_outputs();
        rd_check(3'd4, 32'd0, "R1");

        // R2 R3 R4 default timing over two frames
        run(2 * 15 * 6);

        // R6 shadow write without upload leaves timing alone
        tick(1, 3'd0, 32'h0001_0004);
        rd_check(3'd0, 32'h0001_0004, "R6");
        run(120);
        rd_check(3'd4, 32'd0, "R6");

        // R7 upload with bit0 clear does nothing, set arms, commit clears
        tick(1, 3'd4, 32'hFFFF_FFFE);
        rd_check(3'd4, 32'd0, "R7");
        tick(1, 3'd4, 32'd1);
        rd_check(3'd4, 32'd1, "R7");
        wait_commit();
        rd_check(3'd4, 32'd0, "R7");
        run(2 * htot() * vtot());

        // R5 all-zero fields behave as width 1
        for (int i = 0; i < 4; i++) tick(1, 3'(i), 32'd0);
        tick(1, 3'd4, 32'd1);
        wait_commit();
        check("R5", 64'(htot()), 64'd4, "model line total");
        run(3 * 16);

        // R8 upload strobe on the last pixel of the frame stays armed
        tick(1, 3'd1, 32'h0001_0005);
        tick(1, 3'd4, 32'd1);
        wait_commit();
        run_to_last();
        tick(1, 3'd4, 32'd1);
        rd_check(3'd4, 32'd1, "R8");
        // R8 shadow write in the commit cycle is excluded from that commit
        tick(1, 3'd3, 32'h0002_0002);
        run_to_last();
        tick(1, 3'd1, 32'h0003_0006);
        rd_check(3'd4, 32'd0, "R8");
        rd_check(3'd1, 32'h0003_0006, "R8");
        run(2 * htot() * vtot());

        // R9 path control fields
        tick(1, 3'd5, 32'hFFFF_FFFF);
        rd_check(3'd5, 32'h3FF0_0101, "R9");
        tick(1, 3'd5, 32'h1230_0001);
        rd_check(3'd5, 32'h1230_0001, "R9");

        // random timing sets
        for (int r = 0; r < 10; r++) begin
            w0 = {16'($urandom_range(0, 6)), 16'($urandom_range(0, 6))};
            w1 = {16'($urandom_range(0, 6)), 16'($urandom_range(0, 8))};
            w2 = {16'($urandom_range(0, 4)), 16'($urandom_range(0, 4))};
            w3 = {16'($urandom_range(0, 4)), 16'($urandom_range(0, 6))};
            tick(1, 3'd0, w0);
            run($urandom_range(0, 5));
            tick(1, 3'd1, w1);
            tick(1, 3'd2, w2);
            tick(1, 3'd3, w3);
            rd_check(3'd2, w2, "R6");
            tick(1, 3'd5, $urandom());
            tick(1, 3'd4, 32'd1);
            wait_commit();
            rd_check(3'd4, 32'd0, "R7");
            run(2 * htot() * vtot() + $urandom_range(0, 30));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule